// File: doc/BRIEF.md
# Bidirectional Bus Register Port

This block sits between a 16-bit bidirectional processor data bus and the logic inside the device. The external bus master decides the direction with a read-not-write line. When that line is high, the master is writing. The block releases the bus pins and samples the data the master drives onto them. When the line is low, the master is reading. The block then drives the pins with the data from one internal source.

The block contains a bank of holding registers. These hold configuration words for the rest of the device. Each register has its own load enable, and the loaded value stays on the register's output until that register is loaded again. Read-back data comes from a set of source words. A one-hot set of read enables picks one source, and a combinational AND-OR network builds the result one bit at a time. No internal tri-state drivers are used. An external address decoder produces both sets of enables. That decoder is not part of this block.

The bus, control and enable pins are plain level signals with no valid/ready handshake. The bus master owns the timing, so the block never applies back-pressure.

Top module: `bus_reg_port`

## Requirements
- R1: While `rnw` is low, the block drives `data_bus` in the same cycle with the read-back word chosen by `rd_en`.
- R2: While `rnw` is high, the block leaves `data_bus` undriven, so `data_bus` carries exactly the value the bus master drives.
- R3: On a rising clock edge with `rnw` high, every holding register whose `wr_en` bit is high loads the word present on `data_bus`. Several registers may load the same word on one edge.
- R4: A holding register whose `wr_en` bit is low keeps its value across the clock edge.
- R5: A holding register whose `wr_en` bit is high while `rnw` is low keeps its value.
- R6: Driving `rst_n` low clears every holding register to zero at once, without waiting for a clock edge.
- R7: When `rd_en` has exactly bit k set, the read-back word is `rd_src[k*16 +: 16]`. Holding register i appears on `cfg_q[i*16 +: 16]`.
- R8: When no `rd_en` bit is set, the read-back word is all zeros. At most one `rd_en` bit may be high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rnw | input | 1 | High: master writes and pins float; low: block drives the pins |
| data_bus | inout | 16 | Bidirectional processor data bus |
| wr_en | input | 4 | Load enables, one per holding register |
| rd_en | input | 4 | One-hot read-back source selects |
| rd_src | input | 64 | Read-back source words, source k in bits [k*16 +: 16] |
| cfg_q | output | 64 | Holding register outputs, register i in bits [i*16 +: 16] |

## Verification
The bench attacks the following corner cases:
- **All load enables high at once.** A decoder that assumed a single enable would load only one register.
- **Load enables high while `rnw` is low.** A design that ignored direction would capture the block's own read-back word into the registers.
- **An all-zero read select.** A mux with a default leg would leak a source word onto the bus.
- **Every one-hot select in turn.** A swapped slice or a wrong bit position would show up as the wrong word on the pins.
- **A reset in the middle of the run, checked before any clock edge.** A reset that was synchronous rather than asynchronous would still show stale register contents at that point.

// File: rtl/busreg_pkg.sv
package busreg_pkg;
  localparam int DEF_BUS_W  = 16;
  localparam int DEF_NUM_WR = 4;
  localparam int DEF_NUM_RD = 4;
endpackage

// File: rtl/bus_pad_ctl.sv
module bus_pad_ctl #(
  parameter int W = 16
) (
  inout  wire  [W-1:0] pad,
  input  logic         rnw,
  input  logic [W-1:0] drv_data,
  output logic [W-1:0] smp_data
);
  // Pins float while the master writes, else carry the read-back word.
  assign pad      = rnw ? {W{1'bz}} : drv_data;
  assign smp_data = pad;
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(d));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));
  // R6
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> q == '0);
endmodule

// File: rtl/onehot_andor_mux.sv
module onehot_andor_mux #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] src,
  output logic [W-1:0]   y
);
  // Each output bit is the OR of that bit across sources, each gated by its select.
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [N-1:0] column;
    for (genvar k = 0; k < N; k++) begin : g_src
      assign column[k] = src[k*W + b] & sel[k];
    end
    assign y[b] = |column;
  end
endmodule

// File: rtl/bus_reg_port.sv
module bus_reg_port
  import busreg_pkg::*;
#(
  parameter int BUS_W  = DEF_BUS_W,
  parameter int REG_W  = DEF_BUS_W,
  parameter int NUM_WR = DEF_NUM_WR,
  parameter int NUM_RD = DEF_NUM_RD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rnw,
  inout  wire  [BUS_W-1:0]        data_bus,
  input  logic [NUM_WR-1:0]       wr_en,
  input  logic [NUM_RD-1:0]       rd_en,
  input  logic [NUM_RD*BUS_W-1:0] rd_src,
  output logic [NUM_WR*REG_W-1:0] cfg_q
);
  localparam int CFG_W = NUM_WR * REG_W;

  logic [BUS_W-1:0] rd_word;
  logic [BUS_W-1:0] bus_smp;

  initial begin
    if (REG_W < 1 || REG_W > BUS_W) $error("REG_W must lie in 1..BUS_W");
    if (CFG_W != $bits(cfg_q))      $error("cfg_q width mismatch");
  end

  bus_pad_ctl #(.W(BUS_W)) u_pad (
    .pad      (data_bus),
    .rnw      (rnw),
    .drv_data (rd_word),
    .smp_data (bus_smp)
  );

  onehot_andor_mux #(.W(BUS_W), .N(NUM_RD)) u_mux (
    .sel (rd_en),
    .src (rd_src),
    .y   (rd_word)
  );

  for (genvar i = 0; i < NUM_WR; i++) begin : g_reg
    hold_reg #(.W(REG_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (wr_en[i] & rnw),
      .d     (bus_smp[REG_W-1:0]),
      .q     (cfg_q[i*REG_W +: REG_W])
    );

    // R5
    dir_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[i] && !rnw) |=> $stable(cfg_q[i*REG_W +: REG_W]));
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    // R7
    rd_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rnw && rd_en == NUM_RD'(1) << k) |-> data_bus == rd_src[k*BUS_W +: BUS_W]);
  end

  // R8
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en));
  // R8
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rnw && rd_en == '0) |-> data_bus == '0);
endmodule

// File: tb/bus_reg_port_tb.sv
`timescale 1ns/1ps
module bus_reg_port_tb;
  localparam int W  = 16;
  localparam int NW = 4;
  localparam int NR = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rnw = 1'b1;
  logic [NW-1:0]     wr_en = '0;
  logic [NR-1:0]     rd_en = '0;
  logic [NR*W-1:0]   rd_src = '0;
  logic [NW*W-1:0]   cfg_q;
  logic [W-1:0]      m_val = '0;
  logic              m_drv = 1'b0;
  wire  [W-1:0]      data_bus;

  logic [W-1:0]      model [NW];
  logic              p_rnw;
  logic [NW-1:0]     p_wr;
  int                checks = 0;
  int                errors = 0;

  assign data_bus = m_drv ? m_val : {W{1'bz}};

  always #2 clk = ~clk;

  bus_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .rnw(rnw), .data_bus(data_bus),
    .wr_en(wr_en), .rd_en(rd_en), .rd_src(rd_src), .cfg_q(cfg_q)
  );

  function automatic logic [W-1:0] exp_rd(input logic [NR-1:0] sel, input logic [NR*W-1:0] src);
    logic [W-1:0] r = '0;
    for (int k = 0; k < NR; k++) if (sel[k]) r = r | src[k*W +: W];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string why);
    for (int i = 0; i < NW; i++) begin
      string tag;
      if (why != "") tag = why;
      else if (p_rnw && p_wr[i]) tag = "R3 load";
      else if (p_wr[i]) tag = "R5 no load in read direction";
      else tag = "R4 hold";
      chk(cfg_q[i*W +: W] === model[i], tag, cfg_q[i*W +: W], model[i]);
    end
  endtask

  // Apply one cycle of stimulus at a negedge, check the bus, advance the model.
  task automatic cycle(input logic d_rnw, input logic [NW-1:0] d_wr, input logic [NR-1:0] d_rd,
                       input logic [W-1:0] d_val);
    @(negedge clk);
    check_regs("");
    rnw = d_rnw; wr_en = d_wr; rd_en = d_rd; m_val = d_val; m_drv = d_rnw;
    #1;
    if (d_rnw) chk(data_bus === d_val, "R2 master value on bus", data_bus, d_val);
    else if (d_rd == '0) chk(data_bus === '0, "R8 idle read is zero", data_bus, '0);
    else begin
      logic [W-1:0] e = exp_rd(d_rd, rd_src);
      chk(data_bus === e, "R1/R7 read-back", data_bus, e);
    end
    p_rnw = d_rnw; p_wr = d_wr;
    if (d_rnw) for (int i = 0; i < NW; i++) if (d_wr[i]) model[i] = d_val;
  endtask

  function automatic logic [NR-1:0] rand_rd();
    int k = int'($urandom % (NR + 1));
    return (k == NR) ? '0 : NR'(1) << k;
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    for (int i = 0; i < NW; i++) model[i] = '0;
    p_rnw = 1'b0; p_wr = '0;
    #5;
    check_regs("R6 reset state");
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < NR; k++) rd_src[k*W +: W] = W'(16'h1111 * (k + 1));

    // R3: all registers load the same word on one edge
    cycle(1'b1, '1, '0, 16'hA5C3);
    // R7: each one-hot read select in turn
    for (int k = 0; k < NR; k++) cycle(1'b0, '0, NR'(1) << k, '0);
    // R8: no select gives zeros
    cycle(1'b0, '0, '0, '0);
    // R5: load enables while the block drives the bus
    cycle(1'b0, '1, 4'b0010, '0);
    // R3: single register load, then R4 hold
    cycle(1'b1, 4'b0100, '0, 16'h0F0F);
    cycle(1'b1, '0, '0, 16'hFFFF);

    for (int n = 0; n < 400; n++) begin
      rd_src = {$urandom, $urandom};
      cycle(1'($urandom), NW'($urandom), rand_rd(), W'($urandom));
    end
    @(negedge clk);
    check_regs("");

    // R6: asynchronous clear, observed before any further clock edge
    #0.5 rst_n = 1'b0;
    #0.5;
    for (int i = 0; i < NW; i++) model[i] = '0;
    check_regs("R6 async clear");
    @(negedge clk); rst_n = 1'b1;
    p_rnw = 1'b0; p_wr = '0;
    cycle(1'b1, 4'b1001, '0, 16'h1234);
    cycle(1'b0, '0, 4'b1000, '0);
    @(negedge clk);
    check_regs("");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule